// File: doc/BRIEF.md
# Banked Register File with Pointer Auto-Increment

This block is a byte-wide register file that sits behind a serial-bus slave front end. The front end hands it whole bytes through a simple transaction port: a start pulse, a stop pulse, a byte strobe with a read/write flag, the write byte, and a registered read byte. The first byte written after a start loads an 8-bit register pointer. Each later byte is written to, or read from, the register the pointer selects, and the pointer then steps to the next address, wrapping from 0xFF to 0x00. A read strobe that arrives straight after a start, with no pointer byte, reads at the pointer left by the previous transaction.

Pointer values 0x00 to 0x3F address a shared region that every bank sees. Bit 5 of the shared register at 0x0E picks which bank answers from 0x40 upward. With the bit clear, 0x40 to 0xFF reach the main bank. With the bit set, 0x40 to 0x9C reach a smaller secondary bank that holds interrupt-related settings, and the addresses above it read as zero. A write that changes the select bit applies to the very next byte of the same burst.

Top module: `banked_regfile`

## Requirements
- R1: The first written byte after a start loads the pointer with that byte's value, and no register is written by it.
- R2: After every data byte, read or write, the pointer rises by one and wraps from 0xFF to 0x00. A burst ends only at a stop.
- R3: Addresses 0x00 to 0x3F hold the same registers whatever the bank select is.
- R4: The bank select is bit 5 of register 0x0E and resets to 0. While it is 0, addresses 0x40 to 0xFF reach the main bank.
- R5: While the bank select is 1, addresses 0x40 to 0x9C reach a secondary bank. Its contents are kept apart from the main bank, and neither bank is changed by writes to the other.
- R6: While the bank select is 1, addresses 0x9D to 0xFF read 0x00 and writes to them change no register.
- R7: A write that changes the bank select decides the bank for the next byte of the same burst.
- R8: After reset, every shared and main-bank register holds its address XOR 0x5A, and every secondary-bank register holds its address XOR 0xA5.
- R9: Every register whose address has low nibble 0xF is read-only. A write to it leaves its reset value in place, but the pointer still advances.
- R10: Byte strobes outside a transaction (after a stop, before the next start) change neither the registers nor the pointer. A read right after a start uses the pointer left by the last transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start or repeated-start pulse |
| xfer_stop | input | 1 | Stop pulse; ends the transaction |
| byte_valid | input | 1 | One byte is transferred this cycle |
| byte_rnw | input | 1 | 1 = read byte, 0 = write byte |
| wr_byte | input | 8 | Byte written by the bus master |
| rd_byte | output | 8 | Read byte, valid the cycle after a read strobe |

## Verification
The hardest case to reach is the bank select changing in the middle of a burst. The bank then in force must carry on through the shared region until the pointer crosses 0x40. The bench sets this up with one unbroken write burst that starts at 0x0E, writes the select bit as its first data byte, and runs on until the first byte lands in the secondary bank. Independent reads afterwards show which bank took that byte. Full 256-address sweeps in both bank settings cover the read-zero region, the read-only registers and the reset defaults. A burst that starts at 0xFE makes the pointer wrap.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int          AW         = 8;
    localparam logic [7:0]  SHARED_END = 8'h3F;
    localparam logic [7:0]  UPPER_BASE = 8'h40;
    localparam logic [7:0]  SEC_LAST   = 8'h9C;
    localparam logic [7:0]  CTRL_ADDR  = 8'h0E;
    localparam int          SEL_BIT    = 5;
    localparam int          SHARED_N   = 64;
    localparam int          MAIN_N     = 192;
    localparam int          SEC_N      = int'(SEC_LAST) - int'(UPPER_BASE) + 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] ptr;
    } access_t;

    function automatic logic is_ro(input logic [7:0] a);
        return a[3:0] == 4'hF;
    endfunction

    function automatic logic [7:0] reset_val(input logic [7:0] a, input logic sec);
        logic [7:0] v;
        v = a ^ (sec ? 8'hA5 : 8'h5A);
        if (a == CTRL_ADDR) v[SEL_BIT] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/brf_pointer.sv
module brf_pointer
    import brf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_start,
    input  logic       xfer_stop,
    input  logic       byte_valid,
    input  logic       byte_rnw,
    input  logic [7:0] wr_byte,
    output access_t    acc
);

    phase_e     phase_q;
    logic [7:0] ptr_q;
    logic       strobe;

    assign strobe = byte_valid && !xfer_start && !xfer_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
        end else if (xfer_start) begin
            phase_q <= PH_ADDR;
        end else if (xfer_stop) begin
            phase_q <= PH_IDLE;
        end else if (strobe && phase_q != PH_IDLE) begin
            phase_q <= PH_DATA;
            if (phase_q == PH_ADDR && !byte_rnw) ptr_q <= wr_byte;
            else                                 ptr_q <= ptr_q + 8'd1;
        end
    end

    always_comb begin
        acc.ptr = ptr_q;
        acc.wr  = strobe && !byte_rnw && phase_q == PH_DATA;
        acc.rd  = strobe &&  byte_rnw && phase_q != PH_IDLE;
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (strobe && !byte_rnw && phase_q == PH_ADDR) |=> (ptr_q == $past(wr_byte))); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc.wr || acc.rd) |=> (ptr_q == $past(ptr_q) + 8'd1)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !xfer_start) |=> $stable(ptr_q)); // R10

endmodule

// File: rtl/brf_store.sv
module brf_store
    import brf_pkg::*;
#(
    parameter logic [7:0] BASE  = 8'h00,
    parameter int         DEPTH = 64,
    parameter logic       SEC   = 1'b0,
    localparam int        IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];
    logic [7:0] abs_addr;
    logic       in_range;

    assign abs_addr = BASE + 8'(idx);
    assign in_range = 32'(idx) < DEPTH;
    assign rdata    = in_range ? mem[idx] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= reset_val(BASE + 8'(i), SEC);
            end
        end else if (we && in_range && !is_ro(abs_addr)) begin
            mem[idx] <= wdata;
        end
    end

    AST_RO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (we && in_range && is_ro(abs_addr)) |=> (rdata == $past(rdata) || idx != $past(idx))); // R9

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_start,
    input  logic       xfer_stop,
    input  logic       byte_valid,
    input  logic       byte_rnw,
    input  logic [7:0] wr_byte,
    output logic [7:0] rd_byte
);

    access_t    acc;
    logic       bank_q;
    logic       hit_shared, hit_main, hit_sec;
    logic [7:0] upper_off;
    logic [7:0] sh_rd, mn_rd, sc_rd;

    brf_pointer u_ptr (
        .clk       (clk),
        .rst       (rst),
        .xfer_start(xfer_start),
        .xfer_stop (xfer_stop),
        .byte_valid(byte_valid),
        .byte_rnw  (byte_rnw),
        .wr_byte   (wr_byte),
        .acc       (acc)
    );

    always_comb begin
        upper_off  = acc.ptr - UPPER_BASE;
        hit_shared = acc.ptr <= SHARED_END;
        hit_main   = !hit_shared && !bank_q;
        hit_sec    = !hit_shared &&  bank_q && acc.ptr <= SEC_LAST;
    end

    brf_store #(.BASE(8'h00), .DEPTH(SHARED_N), .SEC(1'b0)) u_shared (
        .clk(clk), .rst(rst), .we(acc.wr && hit_shared),
        .idx(acc.ptr[5:0]), .wdata(wr_byte), .rdata(sh_rd)
    );

    brf_store #(.BASE(UPPER_BASE), .DEPTH(MAIN_N), .SEC(1'b0)) u_main (
        .clk(clk), .rst(rst), .we(acc.wr && hit_main),
        .idx(upper_off), .wdata(wr_byte), .rdata(mn_rd)
    );

    brf_store #(.BASE(UPPER_BASE), .DEPTH(SEC_N), .SEC(1'b1)) u_sec (
        .clk(clk), .rst(rst), .we(acc.wr && hit_sec),
        .idx(upper_off[6:0]), .wdata(wr_byte), .rdata(sc_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= 1'b0;
            rd_byte <= 8'h00;
        end else begin
            if (acc.wr && acc.ptr == CTRL_ADDR) bank_q <= wr_byte[SEL_BIT];
            if (acc.rd) begin
                if (hit_shared)    rd_byte <= sh_rd;
                else if (hit_main) rd_byte <= mn_rd;
                else if (hit_sec)  rd_byte <= sc_rd;
                else               rd_byte <= 8'h00;
            end
        end
    end

    AST_SEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.ptr == CTRL_ADDR) |=> (bank_q == $past(wr_byte[SEL_BIT]))); // R7

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && bank_q && acc.ptr > SEC_LAST) |=> (rd_byte == 8'h00)); // R6

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_shared, hit_main, hit_sec})); // R5

endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0, xfer_stop = 1'b0, byte_valid = 1'b0, byte_rnw = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] rd_byte;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_shared [64];
    logic [7:0] m_main   [192];
    logic [7:0] m_sec    [93];
    logic       m_bank;

    always #4 clk = ~clk;

    banked_regfile dut (.*);

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic ro(input logic [7:0] a);
        return a[3:0] == 4'hF;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        if (a < 8'h40)      return m_shared[a];
        if (!m_bank)        return m_main[a - 8'h40];
        if (a <= 8'h9C)     return m_sec[a - 8'h40];
        return 8'h00;
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
        if (ro(a)) return;
        if (a < 8'h40) begin
            m_shared[a] = d;
            if (a == 8'h0E) m_bank = d[5];
        end else if (!m_bank)     m_main[a - 8'h40] = d;
        else if (a <= 8'h9C)      m_sec[a - 8'h40]  = d;
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp, input logic [7:0] a);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr %02h: actual %02h expected %02h", req, a, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); xfer_stop = 1'b1;
        @(negedge clk); xfer_stop = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_rnw = 1'b0; wr_byte = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic rbyte(output logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_rnw = 1'b1;
        @(negedge clk); byte_valid = 1'b0; d = rd_byte;
    endtask

    task automatic sweep_read(input string req);
        logic [7:0] got;
        pulse_start(); wbyte(8'h00);
        for (int a = 0; a < 256; a++) begin
            rbyte(got);
            chk(req, got, model_rd(8'(a)), 8'(a));
        end
        pulse_stop();
    endtask

    task automatic set_bank(input logic b);
        pulse_start(); wbyte(8'h0E); wbyte(b ? 8'h20 : 8'h00); pulse_stop();
        model_wr(8'h0E, b ? 8'h20 : 8'h00);
    endtask

    initial begin
        logic [7:0] got;
        for (int a = 0; a < 64; a++)  m_shared[a] = 8'(a) ^ 8'h5A;
        for (int a = 0; a < 192; a++) m_main[a]   = 8'(a + 64) ^ 8'h5A;
        for (int a = 0; a < 93; a++)  m_sec[a]    = 8'(a + 64) ^ 8'hA5;
        m_shared[14][5] = 1'b0;
        m_bank = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset rd_byte", rd_byte, 8'h00, 8'h00);

        // R8 R4: defaults through main view
        sweep_read("R8/R4 reset main view");
        // R8 R6: defaults through secondary view
        set_bank(1'b1);
        sweep_read("R8/R6 reset secondary view");
        set_bank(1'b0);

        // R2 R9: one 256-byte write burst in bank 0
        pulse_start(); wbyte(8'h00);
        for (int a = 0; a < 256; a++) begin
            wbyte(8'(a) ^ 8'hC3);
            model_wr(8'(a), 8'(a) ^ 8'hC3);
        end
        pulse_stop();
        sweep_read("R9/R4 main after burst");

        // R5 R6: write every upper address in bank 1
        set_bank(1'b1);
        pulse_start(); wbyte(8'h40);
        for (int a = 64; a < 256; a++) begin
            wbyte(8'(a) ^ 8'h3C);
            model_wr(8'(a), 8'(a) ^ 8'h3C);
        end
        pulse_stop();
        sweep_read("R5/R6/R3 secondary after burst");
        set_bank(1'b0);
        sweep_read("R5/R3 main untouched");

        // R7: select written mid-burst governs the rest of the burst
        pulse_start(); wbyte(8'h0E);
        for (int a = 14; a <= 65; a++) begin
            logic [7:0] d;
            d = (a == 14) ? 8'h20 : 8'(a) ^ 8'h99;
            wbyte(d);
            model_wr(8'(a), d);
        end
        pulse_stop();
        pulse_start(); wbyte(8'h40); rbyte(got); pulse_stop();
        chk("R7 bank switch in burst (sec)", got, 8'h40 ^ 8'h99, 8'h40);
        set_bank(1'b0);
        pulse_start(); wbyte(8'h40); rbyte(got); pulse_stop();
        chk("R7 main not hit", got, model_rd(8'h40), 8'h40);

        // R2: wrap during a read burst
        pulse_start(); wbyte(8'hFE);
        for (int a = 254; a < 258; a++) begin
            rbyte(got);
            chk("R2 wrap", got, model_rd(8'(a)), 8'(a));
        end
        pulse_stop();

        // R1 R10: pointer load, idle strobes ignored, current-address read
        pulse_start(); wbyte(8'h21); pulse_stop();
        wbyte(8'h77);
        rbyte(got);
        pulse_start(); rbyte(got);
        chk("R10 idle ignored / R1 pointer", got, model_rd(8'h21), 8'h21);
        rbyte(got);
        chk("R2 step after current read", got, model_rd(8'h22), 8'h22);
        pulse_stop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule